// File: doc/BRIEF.md
# Serial Receive Channel with Line Status Flags

This block takes an asynchronous serial line, recovers characters from it and holds the most recent one in a single-byte buffer. A character starts with a low start bit and carries eight data bits, least significant first. An optional parity bit and one or two stop bits follow. The line is examined on an oversampling enable, `baud_x16`, that pulses sixteen times per bit period. The enable comes from an external rate generator. Frame shape comes from three plain configuration pins, which are latched when a start bit is detected.

Software-style access uses a simple read port. A read strobe with a select bit returns either the buffered character or an 8-bit status word one cycle later. The status word carries five receive flags (character waiting, parity mismatch, lost character, bad stop bit, line break). Its three low bits mirror the transmitter and modem inputs. Reading the character buffer clears the receive flags by fixed rules. The lost-character flag is cleared only by a buffer read made while no character is waiting. The read port has no back-pressure: a strobe is accepted in every cycle, and its answer with `rd_ack` appears exactly one cycle later, with no stall and no queueing.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, status bits 7..3 read 0 and bits 2 and 1 read 1; bit 0 reads the clear-to-send input once a clock has passed.
- R2: A frame (low start bit, 8 data bits LSB first, optional parity, stop bits) is captured. Status bit 7 (character waiting) is set, and a buffer read (`rd_sel`=0) returns the data byte.
- R3: A buffer read clears status bits 7, 6, 4 and 3. A status read (`rd_sel`=1) changes no flag.
- R4: With `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0, the expected parity bit is the XOR of the data bits; with `cfg_par_odd`=1 it is the inverse. A mismatch sets status bit 6.
- R5: A character that completes while bit 7 is set sets status bit 5 (overrun). That character is dropped, and its parity, stop and break results are not recorded.
- R6: On overrun the older byte stays in the buffer. A buffer read clears bit 5 only if bit 7 was already 0 at that read; otherwise bit 5 stays set.
- R7: A stop-bit position sampled low sets status bit 4. With `cfg_two_stop`=1, either stop position being low sets it.
- R8: Status bit 3 (break) is set only when all data bits, the parity bit (if present) and every stop bit were sampled low.
- R9: A low pulse that is no longer high-free at mid start bit, i.e. high again at the mid-bit sample of the start bit, starts no character. After a low stop bit, the line must return high before a new start is accepted.
- R10: Status bits 2, 1 and 0 follow `tx_buf_empty`, `tx_idle` and `cts_level` with one clock of delay.
- R11: `rd_ack` and `rd_data` answer a read strobe in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_x16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| tx_buf_empty | input | 1 | Transmitter holding buffer empty (status bit 2) |
| tx_idle | input | 1 | Transmitter fully idle (status bit 1) |
| cts_level | input | 1 | Clear-to-send level (status bit 0) |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = character buffer, 1 = status word |
| rd_data | output | 8 | Read result, valid with rd_ack |
| rd_ack | output | 1 | Read answer valid |

## Verification
A framer that drifts in its bit count or mid-bit phase shows up at the ports within one frame. The byte read back is wrong, or a spurious stop-bit or break flag is set on a clean frame. A wrong flag-clear rule is visible at the very next status read after a buffer read; the two-read overrun sequence exposes an overrun flag that clears too early or never clears. A buffer overwritten by a dropped character is visible as a wrong byte on the first read after the overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int REG_W = 8;

  // Status word bit positions (fixed layout)
  localparam int SB_AVAIL = 7;
  localparam int SB_PAR   = 6;
  localparam int SB_OVR   = 5;
  localparam int SB_FRM   = 4;
  localparam int SB_BRK   = 3;
  localparam int SB_TXBUF = 2;
  localparam int SB_TXIDL = 1;
  localparam int SB_CTS   = 0;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_e;

  typedef struct packed {
    logic par_err;
    logic frm_err;
    logic brk;
  } rx_err_t;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  rx_cfg_t           cfg,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output rx_err_t           err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DATA_W - 1);

  fr_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             armed;
  rx_cfg_t          cfg_q;
  logic             par_bit;
  logic             zero_acc;
  logic             frm_acc;
  logic             second;
  logic             expect_par;

  assign expect_par = (^data) ^ cfg_q.par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FR_IDLE;
      cnt      <= '0;
      idx      <= '0;
      armed    <= 1'b0;
      cfg_q    <= '0;
      par_bit  <= 1'b0;
      zero_acc <= 1'b0;
      frm_acc  <= 1'b0;
      second   <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      err      <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          FR_IDLE: begin
            if (rx_s) begin
              armed <= 1'b1;
            end else if (armed) begin
              state <= FR_START;
              cnt   <= '0;
              armed <= 1'b0;
              cfg_q <= cfg;
            end
          end
          FR_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (!rx_s) begin
                state    <= FR_DATA;
                idx      <= '0;
                zero_acc <= 1'b1;
                frm_acc  <= 1'b0;
                second   <= 1'b0;
                par_bit  <= 1'b0;
              end else begin
                state <= FR_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt      <= '0;
              data     <= {rx_s, data[DATA_W-1:1]};
              zero_acc <= zero_acc & ~rx_s;
              if (idx == TOP_IDX) state <= cfg_q.par_en ? FR_PAR : FR_STOP;
              else                idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_PAR: begin
            if (cnt == LAST_CNT) begin
              cnt      <= '0;
              par_bit  <= rx_s;
              zero_acc <= zero_acc & ~rx_s;
              state    <= FR_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt <= '0;
              if (cfg_q.two_stop && !second) begin
                second   <= 1'b1;
                frm_acc  <= frm_acc | ~rx_s;
                zero_acc <= zero_acc & ~rx_s;
              end else begin
                done        <= 1'b1;
                err.frm_err <= frm_acc | ~rx_s;
                err.brk     <= zero_acc & ~rx_s;
                err.par_err <= cfg_q.par_en & (par_bit ^ expect_par);
                state       <= FR_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end

  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == FR_STOP); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BRK_NEEDS_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err.brk) |-> err.frm_err); // R8
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  input  rx_err_t           rx_err,
  input  logic              buf_read,
  input  logic              tx_buf_empty,
  input  logic              tx_idle,
  input  logic              cts_level,
  output logic [REG_W-1:0]  status,
  output logic [DATA_W-1:0] buf_q
);
  logic avail, par_f, ovr_f, frm_f, brk_f;
  logic [2:0] tx_q;
  logic load, lost;

  assign load = done & (~avail | buf_read);
  assign lost = done & avail & ~buf_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail <= 1'b0;
      par_f <= 1'b0;
      frm_f <= 1'b0;
      brk_f <= 1'b0;
      buf_q <= '0;
    end else if (load) begin
      avail <= 1'b1;
      par_f <= rx_err.par_err;
      frm_f <= rx_err.frm_err;
      brk_f <= rx_err.brk;
      buf_q <= rx_data;
    end else if (buf_read) begin
      avail <= 1'b0;
      par_f <= 1'b0;
      frm_f <= 1'b0;
      brk_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovr_f <= 1'b0;
    else if (lost)               ovr_f <= 1'b1;
    else if (buf_read && !avail) ovr_f <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 3'b110;
    else        tx_q <= {tx_buf_empty, tx_idle, cts_level};
  end

  always_comb begin
    status           = '0;
    status[SB_AVAIL] = avail;
    status[SB_PAR]   = par_f;
    status[SB_OVR]   = ovr_f;
    status[SB_FRM]   = frm_f;
    status[SB_BRK]   = brk_f;
    status[SB_TXBUF] = tx_q[2];
    status[SB_TXIDL] = tx_q[1];
    status[SB_CTS]   = tx_q[0];
  end

  AST_AVAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_read && !done) |=> !status[SB_AVAIL]); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_read && status[SB_AVAIL] && status[SB_OVR]) |=> status[SB_OVR]); // R6
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_read && !status[SB_AVAIL]) |=> !status[SB_OVR]); // R6
  AST_OLD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[SB_AVAIL] && !buf_read) |=> ($stable(buf_q) && status[SB_OVR])); // R5
  AST_BRK_WITH_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB_BRK] |-> status[SB_FRM]); // R8
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_x16,
  input  logic             rx_line,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             tx_buf_empty,
  input  logic             tx_idle,
  input  logic             cts_level,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_ack
);
  logic              rx_s;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  rx_err_t           fr_err;
  rx_cfg_t           cfg;
  logic [REG_W-1:0]  status;
  logic [DATA_W-1:0] buf_q;
  logic              buf_read;

  assign cfg      = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign buf_read = rd_en & ~rd_sel;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (rx_line),
    .q (rx_s)
  );

  uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk (clk),
    .rst_n (rst_n),
    .tick (baud_x16),
    .rx_s (rx_s),
    .cfg (cfg),
    .done (fr_done),
    .data (fr_data),
    .err (fr_err)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk (clk),
    .rst_n (rst_n),
    .done (fr_done),
    .rx_data (fr_data),
    .rx_err (fr_err),
    .buf_read (buf_read),
    .tx_buf_empty (tx_buf_empty),
    .tx_idle (tx_idle),
    .cts_level (cts_level),
    .status (status),
    .buf_q (buf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) rd_data <= rd_sel ? status : REG_W'(buf_q);
    end
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack); // R11
  AST_ACK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_ack); // R11
  AST_STATUS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && status[SB_AVAIL]) |=> status[SB_AVAIL]); // R3
endmodule

// File: tb/uart_rx_stat_test.sv
module uart_rx_stat_test;
  localparam int TICK_DIV = 4;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_x16;
  logic       rx_line = 1'b1;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       tx_buf_empty = 1'b1, tx_idle = 1'b1, cts_level = 1'b0;
  logic       rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ack;
  logic [1:0] tdiv = '0;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 1'b1;
  assign baud_x16 = (tdiv == 2'd3);

  uart_rx_stat uut (
    .clk (clk), .rst_n (rst_n), .baud_x16 (baud_x16), .rx_line (rx_line),
    .cfg_par_en (cfg_par_en), .cfg_par_odd (cfg_par_odd), .cfg_two_stop (cfg_two_stop),
    .tx_buf_empty (tx_buf_empty), .tx_idle (tx_idle), .cts_level (cts_level),
    .rd_en (rd_en), .rd_sel (rd_sel), .rd_data (rd_data), .rd_ack (rd_ack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par_v,
                            input logic s0, input logic s1);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(par_v);
    drive_bit(s0);
    if (cfg_two_stop) drive_bit(s1);
    rx_line = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_flags(output logic [7:0] v);
    logic [7:0] s;
    rd(1'b1, s);
    v = s & 8'hF8;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b1, v);
    chk("R1 reset status", v, 8'h06);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    cfg_par_en = 0; cfg_two_stop = 0;
    send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
    rd_flags(v); chk("R2 avail set", v, 8'h80);
    rd_flags(v); chk("R3 status read keeps flags", v, 8'h80);
    @(negedge clk); rd_en = 1; rd_sel = 0;
    @(negedge clk); rd_en = 0;
    chk("R11 ack after read", {7'd0, rd_ack}, 8'h01);
    chk("R2 data byte", rd_data, 8'hA5);
    @(negedge clk);
    chk("R11 ack drops", {7'd0, rd_ack}, 8'h00);
    rd_flags(v); chk("R3 avail cleared", v, 8'h00);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    cfg_par_en = 1; cfg_par_odd = 0; cfg_two_stop = 0;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
    rd_flags(v); chk("R4 even parity ok", v, 8'h80);
    rd(1'b0, v);
    send_frame(8'h3C, 1'b1, 1'b1, 1'b1);
    rd_flags(v); chk("R4 even parity bad", v, 8'hC0);
    rd(1'b0, v); chk("R4 data with bad parity", v, 8'h3C);
    rd_flags(v); chk("R3 parity flag cleared", v, 8'h00);
    cfg_par_odd = 1;
    send_frame(8'h01, 1'b0, 1'b1, 1'b1);
    rd_flags(v); chk("R4 odd parity ok", v, 8'h80);
    rd(1'b0, v);
    send_frame(8'h01, 1'b1, 1'b1, 1'b1);
    rd_flags(v); chk("R4 odd parity bad", v, 8'hC0);
    rd(1'b0, v);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send_frame(8'h11, 1'b0, 1'b1, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1, 1'b1);
    rd_flags(v); chk("R5 overrun set", v, 8'hA0);
    rd(1'b0, v); chk("R6 older byte kept", v, 8'h11);
    rd_flags(v); chk("R6 overrun stays after read with avail", v, 8'h20);
    rd(1'b0, v);
    rd_flags(v); chk("R6 overrun cleared when avail was 0", v, 8'h00);
    send_frame(8'h33, 1'b0, 1'b1, 1'b1);
    send_frame(8'h44, 1'b0, 1'b0, 1'b1);
    rd_flags(v); chk("R5 dropped char errors ignored", v, 8'hA0);
    rd(1'b0, v); chk("R5 buffer holds first", v, 8'h33);
    rd(1'b0, v);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    rd_flags(v); chk("R7 single stop low", v, 8'h90);
    rd(1'b0, v); chk("R7 data with stop low", v, 8'h5A);
    rd_flags(v); chk("R3 frame flag cleared", v, 8'h00);
    cfg_two_stop = 1;
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
    rd_flags(v); chk("R7 second stop low", v, 8'h90);
    rd(1'b0, v);
    send_frame(8'h7E, 1'b0, 1'b1, 1'b1);
    rd_flags(v); chk("R7 two stops high", v, 8'h80);
    rd(1'b0, v); chk("R2 two stop data", v, 8'h7E);
    cfg_two_stop = 0;
  endtask

  task automatic t_break;
    logic [7:0] v;
    cfg_par_en = 1; cfg_par_odd = 0;
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    rd_flags(v); chk("R8 break detected", v, 8'h98);
    rd(1'b0, v); chk("R8 break data", v, 8'h00);
    rd_flags(v); chk("R3 break cleared", v, 8'h00);
    send_frame(8'h00, 1'b1, 1'b0, 1'b0);
    rd_flags(v); chk("R8 parity high no break", v, 8'hD0);
    rd(1'b0, v);
    cfg_par_en = 0;
    cfg_two_stop = 1;
    send_frame(8'h00, 1'b0, 1'b0, 1'b1);
    rd_flags(v); chk("R8 second stop high no break", v, 8'h90);
    rd(1'b0, v);
    cfg_two_stop = 0;
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    rx_line = 1'b0;
    repeat (TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CYC) @(negedge clk);
    rd_flags(v); chk("R9 short low ignored", v, 8'h00);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1);
    rd(1'b0, v); chk("R9 frame after glitch", v, 8'hC3);
    rx_line = 1'b0;
    repeat (12 * BIT_CYC) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    rd_flags(v); chk("R9 long low gives one break", v, 8'h98);
    rd(1'b0, v);
    repeat (2 * BIT_CYC) @(negedge clk);
    rd_flags(v); chk("R9 no restart while low", v, 8'h00);
  endtask

  task automatic t_tx_bits;
    logic [7:0] v;
    tx_buf_empty = 0; tx_idle = 0; cts_level = 1;
    repeat (2) @(negedge clk);
    rd(1'b1, v); chk("R10 tx bits 001", v & 8'h07, 8'h01);
    tx_buf_empty = 1; tx_idle = 0; cts_level = 0;
    repeat (2) @(negedge clk);
    rd(1'b1, v); chk("R10 tx bits 100", v & 8'h07, 8'h04);
    tx_buf_empty = 1; tx_idle = 1; cts_level = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_overrun();
    t_framing();
    t_break();
    t_glitch();
    t_tx_bits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule